// File: doc/BRIEF.md
# SONET frame descrambler with B1 parity monitor

This block sits after frame alignment on a byte-wide SONET stream. It takes one byte per accepted cycle together with a start-of-frame marker on the first framing byte. It tracks the byte position inside the frame by itself and strips the frame-synchronous scrambling from every byte except the two framing bytes. The clear bytes leave the block one cycle later.

Alongside the descrambling it accumulates even bit-interleaved parity over each complete frame as received, that is, on the scrambled bytes. It then compares that parity with the section parity byte carried, after descrambling, in the following frame. A mismatch raises a one-cycle error flag. The flag is aligned with the output byte that carried the parity. Framing, overhead extraction and error counting are left to neighbouring blocks.

Top module: `sonet_b1_descrambler`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` and `b1_err` are 0.
- R2: A byte accepted in cycle N appears on `out_data` with `out_valid` high in cycle N+1. A byte is accepted when `in_valid` is high and either a frame start has been seen since reset or `in_sof` is high.
- R3: Bytes that arrive with `in_valid` high before the first `in_sof` since reset are discarded and produce no `out_valid`.
- R4: The bytes at frame positions 0 and 1 are the framing pair. They pass to `out_data` unchanged. Position 0 is the byte marked by `in_sof`.
- R5: Every byte at position p ≥ 2 is XORed with keystream byte p−2. The keystream bits b[n] start with b[0..6] = 1 and follow b[n] = b[n−7] XOR b[n−6] (polynomial x^7+x^6+1). Keystream byte k is bits 8k..8k+7, and the earliest bit goes to bit 7. The keystream restarts at position 2 of every frame.
- R6: The position advances once per accepted byte. After position ROWS*COLS−1 it wraps to 0, and the next byte is treated as a frame start even without `in_sof`.
- R7: The parity of a frame is the bitwise XOR of all its ROWS*COLS bytes as received (scrambled), including the framing and parity bytes. If the descrambled byte at position COLS (row 2, column 1) of the next frame differs from that parity, `b1_err` is 1 for exactly the cycle in which that byte is on `out_data`.
- R8: When the parity byte matches, `b1_err` stays 0 for the whole frame.
- R9: The parity byte of the first frame after the first `in_sof` is never checked, because no complete frame precedes it.
- R10: If `in_sof` arrives when the expected position is not 0, the frame restarts at position 0, the stored parity is discarded, and the parity byte of the restarted frame is not checked.
- R11: A cycle with `in_valid` low advances no position, keystream or parity, and gives `out_valid` = 0 and `b1_err` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sof | input | 1 | Marks the first framing byte (position 0); read only with `in_valid` |
| in_data | input | 8 | Aligned, scrambled input byte |
| out_valid | output | 1 | Descrambled byte present |
| out_data | output | 8 | Descrambled byte, one cycle after input |
| b1_err | output | 1 | One-cycle parity mismatch pulse on the parity byte |

## Verification
The assertions assume that `in_sof` only counts when `in_valid` is high, and that the input byte is stable within its accepted cycle. They make no assumption about framing-byte values or gaps between bytes. The stimulus raises `in_sof` only together with `in_valid` and changes inputs only on the falling edge. It uses a small frame (3 rows of 8 bytes) so that every position, the wrap without a marker, an early resynchronising marker and a corruption of each of the eight parity bits are all exercised. Idle cycles are placed inside frames, including right before the parity byte.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int KS_W = 7;
  localparam logic [KS_W-1:0] KS_SEED = 7'h7F;
  localparam int SKIP_BYTES = 2;

  // advance the x^7+x^6+1 generator by one bit
  function automatic logic [KS_W-1:0] ks_bit_step(input logic [KS_W-1:0] s);
    return {s[KS_W-2:0], s[KS_W-1] ^ s[KS_W-2]};
  endfunction

  // advance by a whole byte
  function automatic logic [KS_W-1:0] ks_byte_step(input logic [KS_W-1:0] s);
    logic [KS_W-1:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = ks_bit_step(t);
    return t;
  endfunction

  // keystream byte produced from state s, earliest bit in the MSB
  function automatic logic [7:0] ks_byte(input logic [KS_W-1:0] s);
    logic [KS_W-1:0] t;
    logic [7:0] b;
    t = s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      b[7-i] = t[KS_W-1];
      t = ks_bit_step(t);
    end
    return b;
  endfunction
endpackage

// File: rtl/sdm_framepos.sv
module sdm_framepos #(
  parameter int FRAME_LEN = 810,
  parameter int PW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          accept,
  output logic [PW-1:0] pos,
  output logic          resync
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);

  logic [PW-1:0] pos_q;
  logic          locked_q;

  assign accept = in_valid & (locked_q | in_sof);
  assign pos    = in_sof ? '0 : pos_q;
  assign resync = in_valid & in_sof & locked_q & (pos_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (in_valid && in_sof) locked_q <= 1'b1;
      if (accept) pos_q <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end

  // R6
  pos_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pos_q));
endmodule

// File: rtl/sdm_descram.sv
module sdm_descram #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [PW-1:0] pos,
  input  logic [7:0]    raw,
  output logic [7:0]    plain
);
  import sdm_pkg::*;

  logic [KS_W-1:0] ks_q;
  logic [KS_W-1:0] ks_cur;
  logic            skip;

  assign skip   = (pos < PW'(SKIP_BYTES));
  assign ks_cur = (pos == PW'(SKIP_BYTES)) ? KS_SEED : ks_q;
  assign plain  = skip ? raw : (raw ^ ks_byte(ks_cur));

  always_ff @(posedge clk) begin
    if (rst) ks_q <= KS_SEED;
    else if (accept && !skip) ks_q <= ks_byte_step(ks_cur);
  end

  // R5
  ks_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ks_q != '0);
endmodule

// File: rtl/sdm_bip.sv
module sdm_bip #(
  parameter int FRAME_LEN = 810,
  parameter int B1_POS = 90,
  parameter int PW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          resync,
  input  logic [PW-1:0] pos,
  input  logic [7:0]    raw,
  input  logic [7:0]    plain,
  output logic          err
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);
  localparam logic [PW-1:0] B1P  = PW'(B1_POS);

  logic [7:0] acc_q;
  logic [7:0] ref_q;
  logic       ref_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      ref_q    <= '0;
      ref_ok_q <= 1'b0;
      err      <= 1'b0;
    end else begin
      err <= accept && (pos == B1P) && ref_ok_q && (plain != ref_q);
      if (accept) begin
        acc_q <= (pos == '0) ? raw : (acc_q ^ raw);
        if (pos == LAST) begin
          ref_q    <= acc_q ^ raw;
          ref_ok_q <= 1'b1;
        end
      end
      if (resync) ref_ok_q <= 1'b0;
    end
  end

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  // R9
  no_ref_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_ok_q |=> !err);
endmodule

// File: rtl/sonet_b1_descrambler.sv
module sonet_b1_descrambler #(
  parameter int ROWS = 9,
  parameter int COLS = 90
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       b1_err
);
  localparam int FRAME_LEN = ROWS * COLS;
  localparam int PW = $clog2(FRAME_LEN);

  logic          accept;
  logic          resync;
  logic [PW-1:0] pos;
  logic [7:0]    plain;

  sdm_framepos #(.FRAME_LEN(FRAME_LEN), .PW(PW)) u_pos (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .accept(accept), .pos(pos), .resync(resync)
  );

  sdm_descram #(.PW(PW)) u_dsc (
    .clk(clk), .rst(rst), .accept(accept), .pos(pos),
    .raw(in_data), .plain(plain)
  );

  sdm_bip #(.FRAME_LEN(FRAME_LEN), .B1_POS(COLS), .PW(PW)) u_bip (
    .clk(clk), .rst(rst), .accept(accept), .resync(resync), .pos(pos),
    .raw(in_data), .plain(plain), .err(b1_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) out_data <= plain;
    end
  end

  // R2
  sof_gives_out_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> out_valid);
  // R4
  framing_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && pos < PW'(2)) |=> (out_data == $past(in_data)));
  // R7
  err_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
    b1_err |-> out_valid);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !b1_err));
endmodule

// File: tb/test_sonet_b1_descrambler.sv
`timescale 1ns/1ps
module test_sonet_b1_descrambler;
  localparam int ROWS = 3;
  localparam int COLS = 8;
  localparam int FL = ROWS * COLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid;
  logic [7:0] out_data;
  logic b1_err;

  always #2.5 clk = ~clk;

  sonet_b1_descrambler #(.ROWS(ROWS), .COLS(COLS)) i_sonet_b1_descrambler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .b1_err(b1_err)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] key [FL];
  logic [7:0] prev_bip;
  bit   pend = 1'b0;
  bit   e_v;
  logic [7:0] e_d;
  bit   e_e;
  string e_req;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare outputs of the previous cycle, then drive a new input
  task automatic step(input bit v, input bit s, input logic [7:0] d,
                      input bit ev, input logic [7:0] ed, input bit ee, input string req);
    @(negedge clk);
    if (pend) begin
      check({e_req, " out_valid"}, 32'(out_valid), 32'(e_v));
      check({e_req, " b1_err"}, 32'(b1_err), 32'(e_e));
      if (e_v) check({e_req, " out_data"}, 32'(out_data), 32'(e_d));
    end
    in_valid = v; in_sof = s; in_data = d;
    pend = 1'b1; e_v = ev; e_d = ed; e_e = ee; e_req = req;
  endtask

  function automatic logic [7:0] pat(input int fid, input int p, input int sel);
    logic [31:0] x;
    if (sel == 0) return 8'h00;
    if (sel == 1) return 8'hFF;
    x = p * 29 + fid * 7 + 3;
    return x[7:0] ^ 8'(p >> 1);
  endfunction

  // send one frame (or its first n bytes); corrupt != 0 flips parity bits
  task automatic frame(input int fid, input bit sof, input logic [7:0] corrupt,
                       input bit checked, input int n, input int gap_at, input string req);
    logic [7:0] acc;
    logic [7:0] pl, rw;
    bit ee;
    acc = '0;
    for (int p = 0; p < n; p++) begin
      if (p == 0) pl = 8'hF6;
      else if (p == 1) pl = 8'h28;
      else if (p == COLS) pl = prev_bip ^ corrupt;
      else pl = pat(fid, p, fid % 4);
      rw = (p < 2) ? pl : (pl ^ key[p-2]);
      acc ^= rw;
      if (p == gap_at) step(1'b0, 1'b0, 8'hA5, 1'b0, 8'h00, 1'b0, "R11");
      ee = checked && (p == COLS) && (corrupt != 0);
      step(1'b1, sof && (p == 0), rw, 1'b1, pl, ee,
           (p == COLS) ? req : ((p < 2) ? "R4" : "R5"));
    end
    if (n == FL) prev_bip = acc;
  endtask

  initial begin
    logic bits [FL*8];
    for (int i = 0; i < FL*8; i++)
      bits[i] = (i < 7) ? 1'b1 : (bits[i-7] ^ bits[i-6]);
    for (int k = 0; k < FL; k++)
      for (int j = 0; j < 8; j++) key[k][7-j] = bits[8*k+j];
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    prev_bip = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 b1_err", 32'(b1_err), 0);
    @(negedge clk); rst = 1'b0;
    check("R1 out_valid after", 32'(out_valid), 0);
    // R3: bytes before the first marker are dropped
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'(i * 51), 1'b0, 8'h00, 1'b0, "R3");
    // R9: first frame, wrong parity byte, not checked
    frame(1, 1'b1, 8'h5A, 1'b0, FL, -1, "R9");
    // R8: correct parity, idle just before the parity byte
    frame(2, 1'b1, 8'h00, 1'b1, FL, COLS, "R8");
    // R7: each parity bit corrupted in turn; frames without marker use the wrap (R6)
    for (int b = 0; b < 8; b++)
      frame(3 + b, (b % 2) == 0, 8'(1 << b), 1'b1, FL, (b == 3) ? 5 : -1,
            ((b % 2) == 0) ? "R7" : "R6");
    frame(11, 1'b0, 8'h00, 1'b1, FL, -1, "R8");
    frame(12, 1'b1, 8'hFF, 1'b1, FL, -1, "R7");
    // R10: partial frame, then early marker; restarted frame unchecked
    frame(13, 1'b0, 8'h00, 1'b1, COLS + 3, -1, "R10");
    frame(14, 1'b1, 8'h33, 1'b0, FL, -1, "R10");
    frame(15, 1'b0, 8'h81, 1'b1, FL, -1, "R7");
    frame(16, 1'b1, 8'h00, 1'b1, FL, -1, "R8");
    // R11: trailing idle
    step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R11");
    step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R11");
    // R1: reset mid-stream
    @(negedge clk); rst = 1'b1; in_valid = 1'b1; in_sof = 1'b1; pend = 1'b0;
    @(negedge clk); rst = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
    check("R1 out_valid reset", 32'(out_valid), 0);
    check("R1 b1_err reset", 32'(b1_err), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule